// File: doc/BRIEF.md
# Result Store with Lane Masking and Produced-Length Tracking

This block is the result memory that sits between a compute circuit and a host during a batch run. While the execution controller grants the buffer to the compute circuit, the circuit writes results one word at a time over a request/acknowledge handshake. Each write carries an address, a data word and a per-byte lane mask. The block records the furthest byte written since the run began, so the host can learn how much output the run produced without knowing its size in advance.

Once the grant returns to the host side, the host reads a block of words given a start word and a word count. The words stream out on consecutive cycles. A read that arrives while the compute circuit still holds the grant is refused with a one-cycle busy pulse, which the host may retry later. Word width and depth are compile-time parameters. The depth must be a power of two.

Top module: `result_store`

## Requirements
- R1: A write is accepted at a clock edge where `grant`, `wr_req` are high and `wr_ack` is low. The memory is updated at that edge and `wr_ack` is high during the following cycle.
- R2: On an accepted write, byte lane i (bits 8i+7..8i) of the addressed word changes only if `wr_mask[i]` is 1. A write with an all-zero mask is acknowledged and changes neither memory nor `out_len`.
- R3: `wr_ack` is a single-cycle pulse. No write is accepted in a cycle where `wr_ack` is high, so at most one write is accepted per cycle.
- R4: While `grant` is low, `wr_req` is ignored: no acknowledge is given and neither memory nor `out_len` change.
- R5: A host read request sampled at edge k with `grant` low and `hst_words` = N > 0 returns the words at `hst_base`, `hst_base`+1, ... (modulo DEPTH) on `rd_data` with `rd_valid` high, during the N cycles after edges k+1 .. k+N. `rd_valid` is low otherwise. N = 0 returns nothing.
- R6: `run_start` sets `out_len` to 0 at that edge. If a write is accepted at the same edge, `out_len` takes that write's end position instead.
- R7: After an accepted write with a nonzero mask, `out_len` = max(previous length, addr*BYTES + (index of highest set mask bit) + 1). This value is visible in the cycle after the accept edge.
- R8: A host read request sampled while `grant` is high raises `hst_busy` for exactly the following cycle and returns no data. A stream in progress stops when `grant` goes high.
- R9: After reset, `wr_ack`, `hst_busy` and `rd_valid` are low and `out_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | High while the compute circuit owns the buffer |
| run_start | input | 1 | One-cycle pulse at the start of a run; clears the length |
| wr_req | input | 1 | Write request from the compute circuit |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DATA_W | Write data |
| wr_mask | input | BYTES | Byte lane enables, bit i for byte i |
| wr_ack | output | 1 | One-cycle write acknowledge |
| out_len | output | LEN_W | Bytes produced this run (furthest written byte + 1) |
| hst_req | input | 1 | Host block read request pulse |
| hst_base | input | AW | First word of the block |
| hst_words | input | AW+1 | Number of words to return |
| hst_busy | output | 1 | Read refused because the buffer is granted |
| rd_valid | output | 1 | `rd_data` carries a block word |
| rd_data | output | DATA_W | Block read data |

## Verification
`wr_ack` and the new `out_len` both appear in the cycle after the accepting edge. `hst_busy` also appears in the cycle after the refused request edge. Block words begin one cycle later than that, one per cycle, because the read is registered. Each task drives its inputs on the falling edge. It then waits the exact number of rising edges for each result and samples on the next falling edge. Read tasks also check that `rd_valid` is low in the cycle after the last word, and that no second acknowledge follows a write.

// File: rtl/result_store.sv
module result_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         grant,
  input  logic                         run_start,
  input  logic                         wr_req,
  input  logic [$clog2(DEPTH)-1:0]     wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [DATA_W/8-1:0]          wr_mask,
  output logic                         wr_ack,
  output logic [$clog2(DEPTH*(DATA_W/8)+1)-1:0] out_len,
  input  logic                         hst_req,
  input  logic [$clog2(DEPTH)-1:0]     hst_base,
  input  logic [$clog2(DEPTH):0]       hst_words,
  output logic                         hst_busy,
  output logic                         rd_valid,
  output logic [DATA_W-1:0]            rd_data
);
  localparam int BYTES = DATA_W / 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int LEN_W = $clog2(DEPTH * BYTES + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LEN_W-1:0]  top_lane, end_pos, len_base, len_next;
  logic [AW-1:0]     ptr;
  logic [AW:0]       remain;
  logic              active;

  wire take = grant && wr_req && !wr_ack;

  always_comb begin
    top_lane = '0;
    for (int i = 0; i < BYTES; i++)
      if (wr_mask[i]) top_lane = LEN_W'(i + 1);
  end

  assign end_pos  = LEN_W'(wr_addr) * LEN_W'(BYTES) + top_lane;
  assign len_base = run_start ? '0 : out_len;
  assign len_next = (take && |wr_mask && end_pos > len_base) ? end_pos : len_base;

  always_ff @(posedge clk) begin
    for (int b = 0; b < BYTES; b++)
      if (take && wr_mask[b]) mem[wr_addr][8*b +: 8] <= wr_data[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ack  <= 1'b0;
      out_len <= '0;
    end else begin
      wr_ack  <= take;
      out_len <= len_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hst_busy <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      active   <= 1'b0;
      ptr      <= '0;
      remain   <= '0;
    end else begin
      hst_busy <= hst_req && grant;
      rd_valid <= 1'b0;
      if (grant) begin
        active <= 1'b0;
      end else if (active) begin
        rd_data  <= mem[ptr];
        rd_valid <= 1'b1;
        ptr      <= ptr + 1'b1;
        remain   <= remain - 1'b1;
        if (remain == 1) active <= 1'b0;
      end else if (hst_req && hst_words != 0) begin
        active <= 1'b1;
        ptr    <= hst_base;
        remain <= hst_words;
      end
    end
  end
endmodule

// File: rtl/result_store_chk.sv
module result_store_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         grant,
  input logic                         run_start,
  input logic                         wr_req,
  input logic [$clog2(DEPTH)-1:0]     wr_addr,
  input logic [DATA_W-1:0]            wr_data,
  input logic [DATA_W/8-1:0]          wr_mask,
  input logic                         wr_ack,
  input logic [$clog2(DEPTH*(DATA_W/8)+1)-1:0] out_len,
  input logic                         hst_req,
  input logic [$clog2(DEPTH)-1:0]     hst_base,
  input logic [$clog2(DEPTH):0]       hst_words,
  input logic                         hst_busy,
  input logic                         rd_valid,
  input logic [DATA_W-1:0]            rd_data
);
  localparam int TOTAL = DEPTH * (DATA_W / 8);

  p_ack_needs_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> $past(grant && wr_req));

  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> !wr_ack);

  p_ignored_ungranted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && !run_start) |=> (!wr_ack && out_len == $past(out_len)));

  p_len_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_start && !wr_req) |=> out_len == 0);

  p_len_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_start |=> out_len >= $past(out_len));

  p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_len <= TOTAL);

  p_busy_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hst_busy |-> $past(hst_req && grant));

  p_no_data_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!grant));
endmodule

bind result_store result_store_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_result_store.sv
module sim_result_store;
  localparam int DEPTH = 16;
  logic clk = 1'b0, rst_n = 1'b0, grant = 1'b0, run_start = 1'b0;
  logic wr_req = 1'b0, hst_req = 1'b0;
  logic [3:0] wr_addr = '0, hst_base = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] wr_mask = '0;
  logic [4:0] hst_words = '0;
  logic wr_ack, hst_busy, rd_valid;
  logic [6:0] out_len;
  logic [31:0] rd_data;

  logic [31:0] exp_mem [DEPTH];
  int exp_len = 0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  result_store u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] m, input string req);
    wr_addr = a; wr_data = d; wr_mask = m; wr_req = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(wr_ack === 1'b1, {req, " ack after accept"}, wr_ack, 1);
    wr_req = 1'b0;
    for (int b = 0; b < 4; b++)
      if (m[b]) exp_mem[a][8*b +: 8] = d[8*b +: 8];
    for (int b = 0; b < 4; b++)
      if (m[b] && (a * 4 + b + 1) > exp_len) exp_len = a * 4 + b + 1;
    chk(out_len == exp_len, {req, " length"}, out_len, exp_len);
    @(posedge clk); @(negedge clk);
    chk(wr_ack === 1'b0, "R3 ack single cycle", wr_ack, 0);
  endtask

  task automatic do_read(input logic [3:0] base, input int n, input string req);
    hst_base = base; hst_words = 5'(n); hst_req = 1'b1;
    @(posedge clk); @(negedge clk);
    hst_req = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      chk(rd_valid === 1'b1, {req, " valid"}, rd_valid, 1);
      chk(rd_data === exp_mem[(base + i) % DEPTH], {req, " data"}, rd_data, exp_mem[(base + i) % DEPTH]);
    end
    @(posedge clk); @(negedge clk);
    chk(rd_valid === 1'b0, {req, " valid ends"}, rd_valid, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(wr_ack === 0 && hst_busy === 0 && rd_valid === 0, "R9 reset outputs", {wr_ack, hst_busy, rd_valid}, 0);
    chk(out_len == 0, "R9 reset length", out_len, 0);
  endtask

  task automatic t_fill_run;
    grant = 1'b1; run_start = 1'b1;
    @(posedge clk); @(negedge clk);
    run_start = 1'b0; exp_len = 0;
    chk(out_len == 0, "R6 cleared at run start", out_len, 0);
    for (int i = 0; i < DEPTH; i++)
      do_write(4'(i), 32'hC0DE_0000 + 32'(i) * 32'h0101_0101, 4'hF, "R1 R7 full write");
    chk(out_len == 64, "R7 top address length", out_len, 64);
    grant = 1'b0;
    @(posedge clk); @(negedge clk);
    do_read(4'd0, DEPTH, "R5 full block");
  endtask

  task automatic t_mask_run;
    grant = 1'b1; run_start = 1'b1;
    @(posedge clk); @(negedge clk);
    run_start = 1'b0; exp_len = 0;
    chk(out_len == 0, "R6 second run clears", out_len, 0);
    do_write(4'd3, 32'h1122_3344, 4'b0100, "R2 R7 single lane");
    chk(out_len == 15, "R7 end byte index", out_len, 15);
    do_write(4'd1, 32'hFFFF_FFFF, 4'hF, "R7 lower write keeps max");
    chk(out_len == 15, "R7 max kept", out_len, 15);
    do_write(4'd9, 32'hDEAD_BEEF, 4'h0, "R2 zero mask");
    chk(out_len == 15, "R2 zero mask length", out_len, 15);
  endtask

  task automatic t_refused;
    hst_base = 4'd0; hst_words = 5'd4; hst_req = 1'b1;
    @(posedge clk); @(negedge clk);
    hst_req = 1'b0;
    chk(hst_busy === 1'b1, "R8 busy while granted", hst_busy, 1);
    chk(rd_valid === 1'b0, "R8 no data while granted", rd_valid, 0);
    @(posedge clk); @(negedge clk);
    chk(hst_busy === 1'b0, "R8 busy one cycle", hst_busy, 0);
    repeat (4) begin
      @(posedge clk); @(negedge clk);
      chk(rd_valid === 1'b0, "R8 refused read stays silent", rd_valid, 0);
    end
  endtask

  task automatic t_ungranted_write;
    grant = 1'b0;
    wr_addr = 4'd12; wr_data = 32'h5555_AAAA; wr_mask = 4'hF; wr_req = 1'b1;
    repeat (4) begin
      @(posedge clk); @(negedge clk);
      chk(wr_ack === 1'b0, "R4 no ack without grant", wr_ack, 0);
    end
    wr_req = 1'b0;
    chk(out_len == 15, "R4 length untouched", out_len, 15);
    do_read(4'd0, DEPTH, "R2 R4 memory after masked run");
  endtask

  task automatic t_edge_reads;
    do_read(4'd14, 4, "R5 wrap read");
    do_read(4'd5, 0, "R5 zero length");
    do_read(4'd7, 1, "R5 single word");
  endtask

  initial begin
    t_reset();
    t_fill_run();
    t_mask_run();
    t_refused();
    t_ungranted_write();
    t_edge_reads();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule